// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands, four bits each by default, with one add-and-shift step per clock, and returns a product twice as wide. A one-cycle start strobe captures the multiplicand into a holding register. The same strobe places the multiplier in the low half of a double-width accumulator and clears the high half.

On every following cycle the block inspects the lowest accumulator bit. When that bit is 1, the multiplicand is added into the high half. The whole accumulator, together with the carry out of that add, then moves one place to the right. Multiplier bits leave through the bottom as partial-product bits enter from the top.

After as many steps as the operand width, the accumulator holds the product, and a done flag pulses for one cycle. The product output is the accumulator itself. It therefore shows intermediate values while a multiply runs, and it holds the result until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While synchronous reset is high at a clock edge, the following cycle shows product = 0 and done = 0.
- R2: A start sampled while idle loads the operands, and the next cycle shows product = {zeros, multiplier}, with the multiplier in the low half.
- R3: During each step, the new high half is the old high half plus the multiplicand if bit 0 of the product is 1, or the old high half unchanged if it is 0. The combined register then shifts right by one bit.
- R4: The carry out of each step's add enters the top bit of the product during that step's shift. With both operands at 15 the result is 225.
- R5: Exactly OPW steps follow a load. Done is high for exactly one cycle, the cycle after the last step's edge, and the product is final in that cycle.
- R6: While idle and without start, the product holds its value and done stays low.
- R7: A start that arrives while a multiply is running is ignored. The running multiply keeps its operands and its completion time.
- R8: For every pair of operands, the product in the done cycle equals multiplicand times multiplier.
- R9: Multiplicand 1001 times multiplier 1001 finishes with high half 0101 and low half 0001 (decimal 81).
- R10: A start sampled in the cycle where done is high is accepted, because the block is already idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that begins a multiply when the block is idle |
| mcand | input | OPW | Multiplicand, captured on an accepted start |
| mplier | input | OPW | Multiplier, captured on an accepted start |
| product | output | 2*OPW | Accumulator contents; the product in the done cycle and until the next load |
| done | output | 1 | One-cycle pulse marking a finished product |

## Verification
The bench runs a behavioural model next to the design and compares the outputs on every cycle. It sweeps all 256 operand pairs, so the add-or-skip decision, the shift and the step count are each exercised against every bit pattern.

The cases it targets most are the following. A design that drops the add carry fails 15 times 15 and every other high-half overflow. A design that runs one step too many or too few raises done at the wrong cycle or shows a half-shifted product. A design that accepts start while busy reloads its operands part way through a multiply. A design that treats the done cycle as busy loses a start issued back to back with the previous result.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } mul_phase_e;

  // Counter width needed to index a given number of steps (at least one bit).
  function automatic int step_cnt_width(input int steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import smul_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  output logic                               load_fire,
  output logic                               step_fire,
  output logic                               last_step,
  output logic                               busy,
  output logic                               done,
  output logic [step_cnt_width(OPW)-1:0]     iter_cnt
);
  localparam int CW = step_cnt_width(OPW);
  localparam logic [CW-1:0] LAST_IDX = CW'(OPW - 1);

  mul_phase_e phase_q;

  assign busy      = (phase_q == PH_RUN);
  assign load_fire = start && !busy;
  assign step_fire = busy;
  assign last_step = step_fire && (iter_cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      iter_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_step;
      if (load_fire) begin
        phase_q  <= PH_RUN;
        iter_cnt <= '0;
      end else if (last_step) begin
        phase_q  <= PH_IDLE;
        iter_cnt <= '0;
      end else if (step_fire) begin
        iter_cnt <= iter_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mul_addstep.sv
module mul_addstep #(
  parameter int OPW = 4
) (
  input  logic [2*OPW-1:0] acc_in,
  input  logic [OPW-1:0]   mcand,
  output logic [2*OPW-1:0] acc_out,
  output logic             add_carry
);
  localparam int AW = 2 * OPW;

  // Conditional add into the high half, keeping the carry as an extra bit.
  function automatic logic [OPW:0] cond_add(input logic [OPW-1:0] hi,
                                            input logic [OPW-1:0] b,
                                            input logic           sel);
    return {1'b0, hi} + (sel ? {1'b0, b} : '0);
  endfunction

  logic [OPW:0]   hi_sum;
  logic [OPW-1:0] lo_half;

  assign lo_half   = acc_in[OPW-1:0];
  assign hi_sum    = cond_add(acc_in[AW-1:OPW], mcand, acc_in[0]);
  assign add_carry = hi_sum[OPW];
  // Carry plus sum plus low half, shifted right by one place.
  assign acc_out   = {hi_sum, lo_half[OPW-1:1]};

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int OPW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_fire,
  input  logic               step_fire,
  input  logic [OPW-1:0]     mcand,
  input  logic [OPW-1:0]     mplier,
  output logic [2*OPW-1:0]   acc,
  output logic               add_carry
);
  localparam int AW = 2 * OPW;

  logic [OPW-1:0] b_q;
  logic [AW-1:0]  acc_next;

  mul_addstep #(.OPW(OPW)) u_step (
    .acc_in   (acc),
    .mcand    (b_q),
    .acc_out  (acc_next),
    .add_carry(add_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= '0;
      acc <= '0;
    end else if (load_fire) begin
      b_q <= mcand;
      acc <= {{OPW{1'b0}}, mplier};
    end else if (step_fire) begin
      acc <= acc_next;
    end
  end

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int OPW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OPW-1:0]     mcand,
  input  logic [OPW-1:0]     mplier,
  output logic [2*OPW-1:0]   product,
  output logic               done
);
  localparam int CW = smul_pkg::step_cnt_width(OPW);

  logic          load_fire;
  logic          step_fire;
  logic          last_step;
  logic          busy;
  logic          add_carry;
  logic [CW-1:0] iter_cnt;

  mul_ctrl #(.OPW(OPW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load_fire(load_fire),
    .step_fire(step_fire),
    .last_step(last_step),
    .busy     (busy),
    .done     (done),
    .iter_cnt (iter_cnt)
  );

  mul_datapath #(.OPW(OPW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_fire(load_fire),
    .step_fire(step_fire),
    .mcand    (mcand),
    .mplier   (mplier),
    .acc      (product),
    .add_carry(add_carry)
  );

endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int OPW = 4,
  parameter int CW  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [OPW-1:0]     mplier,
  input logic [2*OPW-1:0]   product,
  input logic               done,
  input logic               busy,
  input logic               load_fire,
  input logic               step_fire,
  input logic               add_carry,
  input logic [CW-1:0]      iter_cnt
);
  localparam int AW = 2 * OPW;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (product == '0 && !done)); // R1

  AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> (product == {{OPW{1'b0}}, $past(mplier)})); // R2

  AST_SKIP_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !product[0]) |=> (product == ($past(product) >> 1))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> (product[AW-1] == $past(add_carry))); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (busy && iter_cnt == CW'(OPW - 1)) |=> (done && !busy)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(product) && !done)); // R6

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start && iter_cnt != CW'(OPW - 1)) |=> busy); // R7

endmodule

bind shift_add_mul shift_add_mul_chk #(.OPW(OPW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mplier   (mplier),
  .product  (product),
  .done     (done),
  .busy     (busy),
  .load_fire(load_fire),
  .step_fire(step_fire),
  .add_carry(add_carry),
  .iter_cnt (iter_cnt)
);

// File: tb/tb_shift_add_mul.sv
`timescale 1ns / 1ps
module tb_shift_add_mul;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic [2*W-1:0] product;
  logic         done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string phase = "R3";

  // Behavioural reference state.
  int  m_b = 0, m_acc = 0, m_cnt = 0;
  bit  m_busy = 0, m_done = 0;

  always #2.5 clk = ~clk;

  shift_add_mul #(.OPW(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .mcand(mcand), .mplier(mplier),
    .product(product), .done(done)
  );

  task automatic check(input string tag, input int actual, input int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_b = 0; m_acc = 0; m_cnt = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        int hi;
        hi = m_acc / 16 + ((m_acc % 2 == 1) ? m_b : 0);
        m_acc = (hi * 16 + m_acc % 16) / 2;
        m_cnt++;
        if (m_cnt == W) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        m_b = int'(mcand);
        m_acc = int'(mplier);
        m_cnt = 0;
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(phase, int'(product), m_acc);
      check("R5", int'(done), int'(m_done));
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Drive a start and land on the negedge where done should be high.
  task automatic run_mul(input int a, input int b, input string tag);
    @(negedge clk);
    start = 1'b1; mcand = W'(a); mplier = W'(b);
    @(negedge clk);
    start = 1'b0;
    check("R2", int'(product), b);
    repeat (W) @(negedge clk);
    check("R5", int'(done), 1);
    check(tag, int'(product), a * b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(product), 0);
    check("R1", int'(done), 0);
    rst = 1'b0;

    phase = "R4";
    run_mul(15, 15, "R4");

    phase = "R9";
    run_mul(9, 9, "R9");
    check("R9", int'(product), 8'h51);

    phase = "R6";
    repeat (3) @(negedge clk);
    check("R6", int'(product), 81);
    check("R6", int'(done), 0);

    phase = "R3";
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_mul(a, b, "R8");

    // Start while busy must not disturb the running multiply.
    phase = "R7";
    @(negedge clk);
    start = 1'b1; mcand = 4'd7; mplier = 4'd6;
    @(negedge clk);
    check("R2", int'(product), 6);
    mcand = 4'd13; mplier = 4'd11;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 1) @(negedge clk);
    check("R7", int'(done), 1);
    check("R7", int'(product), 42);

    // Back-to-back start in the done cycle.
    phase = "R10";
    start = 1'b1; mcand = 4'd12; mplier = 4'd5;
    @(negedge clk);
    start = 1'b0;
    check("R10", int'(product), 5);
    repeat (W) @(negedge clk);
    check("R10", int'(done), 1);
    check("R10", int'(product), 60);

    // Reset in the middle of a multiply.
    phase = "R1";
    start = 1'b1; mcand = 4'd3; mplier = 4'd15;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(product), 0);
    check("R1", int'(done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule